// File: doc/BRIEF.md
# Dual 16-bit SIMD ALU

This block is the add/subtract stage of a DSP datapath. It takes two 32-bit register operands and treats them as whole words or as pairs of 16-bit halves. One mode field picks the operation shape. It can do a single word add or subtract, or a single 16-bit operation on any chosen half of each operand. It can run two independent 16-bit operations side by side, or four 16-bit operations that fill two results. It can also form the sum and the difference of the same two words at once.

The block has two 32-bit result paths, P and Q. A write mask for each half of each result tells the register file which halves to store. Carry and overflow flags come out per result half. In the paired and quad 16-bit forms, a crossover input swaps the two halves of each result, and their flags move with them. Every result, flag and mask is registered, and it appears one cycle after an input strobe, together with an output valid.

Top module: `simd_alu`

## Requirements
- R1: Mode 0 (word): resP is opA+opB when subLo=0 and opA−opB when subLo=1, modulo 2^32. wrMaskP=11 and wrMaskQ=00. carryFlag[1] holds the carry out; for subtraction, 1 means no borrow. ovfFlag[1] holds signed overflow.
- R2: Mode 1 (half): aHighSel and bHighSel pick bits 31:16 (1) or 15:0 (0) of each operand. These are combined with the operator subLo. The 16-bit result goes into the half of resP chosen by dstHighSel (1 = high), and the other half reads 0. wrMaskP is one-hot: bit 1 is the high half, bit 0 the low half.
- R3: Mode 2 (pair): the high half is opA[31:16] op opB[31:16], with subHi as the operator. The low half is opA[15:0] op opB[15:0], with subLo as the operator. Each half wraps modulo 2^16, and no carry passes between halves. wrMaskP=11 and wrMaskQ=00.
- R4: Mode 3 (quad): resP is formed as in R3. resQ uses the opposite operator in each half. Both masks are 11.
- R5: Mode 4 (sum and difference): resP=opA+opB and resQ=opA−opB. Both masks are 11. Flags sit in bit 1 (sum) and bit 3 (difference).
- R6: crossHalves=1 swaps the two halves of each 16-bit-form result in modes 2 and 3, and swaps their flags with them. In modes 0, 1 and 4 it has no effect.
- R7: Flag bit k maps to a result half: 0 = P low, 1 = P high, 2 = Q low, 3 = Q high. In 16-bit forms, a set bit is the carry or overflow of the 16-bit operation that lands in that half. Bits for halves that get no result read 0.
- R8: Modes 5 to 7 are reserved. They write nothing: both masks, both results and all flags are 0.
- R9: outValid rises in the cycle after inValid is sampled high. The matching results, flags and masks appear in that same cycle.
- R10: When inValid is low, the next cycle has outValid=0 and both masks 00. The results and flags keep their previous values.
- R11: While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| mode | input | 3 | Operation shape, 0 to 4 (5 to 7 reserved) |
| subHi | input | 1 | High-half operator, 1 = subtract |
| subLo | input | 1 | Low-half or word operator, 1 = subtract |
| aHighSel | input | 1 | Half of opA used in mode 1 |
| bHighSel | input | 1 | Half of opB used in mode 1 |
| dstHighSel | input | 1 | Destination half in mode 1 |
| crossHalves | input | 1 | Swap destination halves in modes 2 and 3 |
| outValid | output | 1 | Registered results valid |
| resP | output | 32 | First result |
| resQ | output | 32 | Second result |
| wrMaskP | output | 2 | Half write enables for resP |
| wrMaskQ | output | 2 | Half write enables for resQ |
| ovfFlag | output | 4 | Signed overflow per result half |
| carryFlag | output | 4 | Carry out per result half |

## Verification
Most faults in this block show up one cycle after the strobe that exposes them. A lane wired to the wrong operator, a carry leaking across the 16-bit boundary, or a swap applied in the wrong mode gives a wrong result or flag bit on that very output. A wrong decode of the mode shows as a wrong write mask in the same cycle. A fault in the hold or idle logic appears on the first cycle after the strobe drops: a mask that stays set, or a result that moves.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_WORD    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_HALF    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_PAIR    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_QUAD    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_SUMDIFF = 3'd4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_W32,
    SEL_H16,
    SEL_PAIR16,
    SEL_QUAD16,
    SEL_SUMDIFF
  } resSel_e;

  typedef struct packed {
    logic    load;
    resSel_e sel;
    logic    swap;
    logic    dstHi;
    logic    subHi;
    logic    subLo;
    logic    aHi;
    logic    bHi;
  } ctrlStrobe_t;

endpackage

// File: rtl/simd_alu_addsub.sv
module simd_alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);

  logic [W-1:0] yEff;
  logic [W:0]   wide;

  always_comb begin
    yEff  = sub ? ~y : y;
    wide  = {1'b0, x} + {1'b0, yEff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    carry = wide[W];
    ovf   = (x[W-1] == yEff[W-1]) && (sum[W-1] != x[W-1]);
  end

endmodule

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [MODE_W-1:0] mode,
  input  logic              subHi,
  input  logic              subLo,
  input  logic              aHighSel,
  input  logic              bHighSel,
  input  logic              dstHighSel,
  input  logic              crossHalves,
  output ctrlStrobe_t       strobe,
  output logic              outValid,
  output logic [1:0]        wrMaskP,
  output logic [1:0]        wrMaskQ
);

  resSel_e    sel;
  logic [1:0] nextMaskP;
  logic [1:0] nextMaskQ;

  always_comb begin
    case (mode)
      MODE_WORD:    sel = SEL_W32;
      MODE_HALF:    sel = SEL_H16;
      MODE_PAIR:    sel = SEL_PAIR16;
      MODE_QUAD:    sel = SEL_QUAD16;
      MODE_SUMDIFF: sel = SEL_SUMDIFF;
      default:      sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.load  = inValid;
    strobe.sel   = sel;
    strobe.swap  = crossHalves && ((sel == SEL_PAIR16) || (sel == SEL_QUAD16));
    strobe.dstHi = dstHighSel;
    strobe.subHi = subHi;
    strobe.subLo = subLo;
    strobe.aHi   = aHighSel;
    strobe.bHi   = bHighSel;
  end

  always_comb begin
    nextMaskP = 2'b00;
    nextMaskQ = 2'b00;
    case (sel)
      SEL_W32, SEL_PAIR16: nextMaskP = 2'b11;
      SEL_H16:             nextMaskP = dstHighSel ? 2'b10 : 2'b01;
      SEL_QUAD16, SEL_SUMDIFF: begin
        nextMaskP = 2'b11;
        nextMaskQ = 2'b11;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wrMaskP  <= 2'b00;
      wrMaskQ  <= 2'b00;
    end else begin
      outValid <= inValid;
      wrMaskP  <= inValid ? nextMaskP : 2'b00;
      wrMaskQ  <= inValid ? nextMaskQ : 2'b00;
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R10
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (wrMaskP == 2'b00 && wrMaskQ == 2'b00));

  // R4
  qmask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrMaskQ != 2'b00) |-> (wrMaskP == 2'b11));

endmodule

// File: rtl/simd_alu_dp.sv
module simd_alu_dp
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] resP,
  output logic [WORD_W-1:0] resQ,
  output logic [3:0]        ovfFlag,
  output logic [3:0]        carryFlag
);

  localparam int HALF_W = WORD_W / 2;
  localparam int LANES  = 4;

  logic [WORD_W-1:0] sumW, diffW;
  logic              sumC, diffC, sumV, diffV;
  logic [HALF_W-1:0] selA, selB;

  logic [LANES-1:0][HALF_W-1:0] laneS;
  logic [LANES-1:0]             laneC;
  logic [LANES-1:0]             laneV;

  logic [WORD_W-1:0] pairP, pairQ;
  logic [1:0]        fvP, fcP, fvQ, fcQ;

  logic [WORD_W-1:0] nextP, nextQ;
  logic [3:0]        nextOvf, nextCy;

  simd_alu_addsub #(.W(WORD_W)) u_sum (
    .x(opA), .y(opB), .sub(1'b0), .sum(sumW), .carry(sumC), .ovf(sumV)
  );

  simd_alu_addsub #(.W(WORD_W)) u_diff (
    .x(opA), .y(opB), .sub(1'b1), .sum(diffW), .carry(diffC), .ovf(diffV)
  );

  assign selA = strobe.aHi ? opA[WORD_W-1:HALF_W] : opA[HALF_W-1:0];
  assign selB = strobe.bHi ? opB[WORD_W-1:HALF_W] : opB[HALF_W-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int QSIDE = k / 2;
    localparam int HSIDE = k % 2;
    logic              laneSub;
    logic [HALF_W-1:0] laneX, laneY;

    always_comb begin
      laneSub = (HSIDE == 1) ? strobe.subHi : strobe.subLo;
      if (QSIDE == 1) laneSub = ~laneSub;
      if (strobe.sel == SEL_H16) begin
        laneX = selA;
        laneY = selB;
      end else begin
        laneX = opA[HSIDE*HALF_W +: HALF_W];
        laneY = opB[HSIDE*HALF_W +: HALF_W];
      end
    end

    simd_alu_addsub #(.W(HALF_W)) u_lane (
      .x(laneX), .y(laneY), .sub(laneSub),
      .sum(laneS[k]), .carry(laneC[k]), .ovf(laneV[k])
    );
  end

  always_comb begin
    pairP = strobe.swap ? {laneS[0], laneS[1]} : {laneS[1], laneS[0]};
    pairQ = strobe.swap ? {laneS[2], laneS[3]} : {laneS[3], laneS[2]};
    fvP   = strobe.swap ? {laneV[0], laneV[1]} : {laneV[1], laneV[0]};
    fcP   = strobe.swap ? {laneC[0], laneC[1]} : {laneC[1], laneC[0]};
    fvQ   = strobe.swap ? {laneV[2], laneV[3]} : {laneV[3], laneV[2]};
    fcQ   = strobe.swap ? {laneC[2], laneC[3]} : {laneC[3], laneC[2]};
  end

  always_comb begin
    nextP   = '0;
    nextQ   = '0;
    nextOvf = 4'b0000;
    nextCy  = 4'b0000;
    case (strobe.sel)
      SEL_W32: begin
        nextP   = strobe.subLo ? diffW : sumW;
        nextOvf = {2'b00, (strobe.subLo ? diffV : sumV), 1'b0};
        nextCy  = {2'b00, (strobe.subLo ? diffC : sumC), 1'b0};
      end
      SEL_H16: begin
        nextP   = strobe.dstHi ? {laneS[0], {HALF_W{1'b0}}}
                               : {{HALF_W{1'b0}}, laneS[0]};
        nextOvf = {2'b00, strobe.dstHi ? {laneV[0], 1'b0} : {1'b0, laneV[0]}};
        nextCy  = {2'b00, strobe.dstHi ? {laneC[0], 1'b0} : {1'b0, laneC[0]}};
      end
      SEL_PAIR16: begin
        nextP   = pairP;
        nextOvf = {2'b00, fvP};
        nextCy  = {2'b00, fcP};
      end
      SEL_QUAD16: begin
        nextP   = pairP;
        nextQ   = pairQ;
        nextOvf = {fvQ, fvP};
        nextCy  = {fcQ, fcP};
      end
      SEL_SUMDIFF: begin
        nextP   = sumW;
        nextQ   = diffW;
        nextOvf = {diffV, 1'b0, sumV, 1'b0};
        nextCy  = {diffC, 1'b0, sumC, 1'b0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resP      <= '0;
      resQ      <= '0;
      ovfFlag   <= 4'b0000;
      carryFlag <= 4'b0000;
    end else if (strobe.load) begin
      resP      <= nextP;
      resQ      <= nextQ;
      ovfFlag   <= nextOvf;
      carryFlag <= nextCy;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(resP) && $stable(resQ) && $stable(ovfFlag) && $stable(carryFlag)));

  // R5
  sumdiff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.sel == SEL_SUMDIFF) |=> (resP == resQ + ($past(opB) << 1)));

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [MODE_W-1:0] mode,
  input  logic              subHi,
  input  logic              subLo,
  input  logic              aHighSel,
  input  logic              bHighSel,
  input  logic              dstHighSel,
  input  logic              crossHalves,
  output logic              outValid,
  output logic [WORD_W-1:0] resP,
  output logic [WORD_W-1:0] resQ,
  output logic [1:0]        wrMaskP,
  output logic [1:0]        wrMaskQ,
  output logic [3:0]        ovfFlag,
  output logic [3:0]        carryFlag
);

  ctrlStrobe_t strobe;

  simd_alu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .subHi(subHi), .subLo(subLo), .aHighSel(aHighSel), .bHighSel(bHighSel),
    .dstHighSel(dstHighSel), .crossHalves(crossHalves),
    .strobe(strobe), .outValid(outValid), .wrMaskP(wrMaskP), .wrMaskQ(wrMaskQ)
  );

  simd_alu_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .resP(resP), .resQ(resQ), .ovfFlag(ovfFlag), .carryFlag(carryFlag)
  );

endmodule

// File: tb/simd_alu_bench.sv
module simd_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam int VW = 149;

  // {mode, subHi, subLo, aHi, bHi, dHi, cross, opA, opB, expP, expQ, mP, mQ, ovf, cy}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 6'b000000, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h00000000, 2'b11, 2'b00, 4'b0010, 4'b0000},
    {3'd0, 6'b010000, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 32'h00000000, 2'b11, 2'b00, 4'b0000, 4'b0000},
    {3'd0, 6'b000000, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 32'h00000000, 2'b11, 2'b00, 4'b0000, 4'b0010},
    {3'd1, 6'b011001, 32'h12340000, 32'h00000034, 32'h00001200, 32'h00000000, 2'b01, 2'b00, 4'b0000, 4'b0001},
    {3'd1, 6'b000110, 32'h00007FFF, 32'h00010000, 32'h80000000, 32'h00000000, 2'b10, 2'b00, 4'b0010, 4'b0000},
    {3'd2, 6'b010000, 32'h00030010, 32'h00020020, 32'h0005FFF0, 32'h00000000, 2'b11, 2'b00, 4'b0000, 4'b0000},
    {3'd2, 6'b000001, 32'hFFFF7FFF, 32'h00010001, 32'h80000000, 32'h00000000, 2'b11, 2'b00, 4'b0010, 4'b0001},
    {3'd3, 6'b000000, 32'h00100100, 32'h00010200, 32'h00110300, 32'h000FFF00, 2'b11, 2'b11, 4'b0000, 4'b1000},
    {3'd3, 6'b100001, 32'h00080005, 32'h00030002, 32'h00070005, 32'h0003000B, 2'b11, 2'b11, 4'b0000, 4'b1001},
    {3'd4, 6'b000001, 32'h80000000, 32'h00000001, 32'h80000001, 32'h7FFFFFFF, 2'b11, 2'b11, 4'b1000, 4'b1000},
    {3'd7, 6'b000000, 32'h12345678, 32'h9ABCDEF0, 32'h00000000, 32'h00000000, 2'b00, 2'b00, 4'b0000, 4'b0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [2:0]  mode = '0;
  logic        subHi = 1'b0, subLo = 1'b0, aHighSel = 1'b0, bHighSel = 1'b0;
  logic        dstHighSel = 1'b0, crossHalves = 1'b0;
  logic        outValid;
  logic [31:0] resP, resQ;
  logic [1:0]  wrMaskP, wrMaskQ;
  logic [3:0]  ovfFlag, carryFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_alu u_simd_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB), .mode(mode),
    .subHi(subHi), .subLo(subLo), .aHighSel(aHighSel), .bHighSel(bHighSel),
    .dstHighSel(dstHighSel), .crossHalves(crossHalves),
    .outValid(outValid), .resP(resP), .resQ(resQ), .wrMaskP(wrMaskP), .wrMaskQ(wrMaskQ),
    .ovfFlag(ovfFlag), .carryFlag(carryFlag)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [2:0] m, input logic c);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return c ? "R6" : "R3";
      3'd3: return c ? "R6" : "R4";
      3'd4: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [VW-1:0] v);
    {mode, subHi, subLo, aHighSel, bHighSel, dstHighSel, crossHalves, opA, opB} = v[VW-1:76];
    inValid = 1'b1;
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs held at zero in reset
    check("R11", "outValid", {31'b0, outValid}, 32'd0);
    check("R11", "resP", resP, 32'd0);
    check("R11", "resQ", resQ, 32'd0);
    check("R11", "masks", {28'b0, wrMaskP, wrMaskQ}, 32'd0);
    check("R11", "flags", {24'b0, ovfFlag, carryFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: no output before the capturing edge, valid right after it
    drive(VEC[0]);
    #1;
    check("R9", "outValid before edge", {31'b0, outValid}, 32'd0);
    @(negedge clk);
    check("R9", "outValid after edge", {31'b0, outValid}, 32'd1);

    // Vector table walk, one strobe per cycle
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string rq;
      v = VEC[i];
      rq = reqOf(v[VW-1:VW-3], v[VW-9]);
      drive(v);
      @(negedge clk);
      check(rq, "outValid", {31'b0, outValid}, 32'd1);
      check(rq, "resP", resP, v[75:44]);
      check(rq, "resQ", resQ, v[43:12]);
      check(rq, "wrMaskP", {30'b0, wrMaskP}, {30'b0, v[11:10]});
      check(rq, "wrMaskQ", {30'b0, wrMaskQ}, {30'b0, v[9:8]});
      check("R7", "ovfFlag", {28'b0, ovfFlag}, {28'b0, v[7:4]});
      check("R7", "carryFlag", {28'b0, carryFlag}, {28'b0, v[3:0]});
    end

    // R10: idle cycle after a sum/difference strobe holds results, clears masks
    drive(VEC[9]);
    @(negedge clk);
    inValid = 1'b0;
    opA = 32'hDEADBEEF;
    opB = 32'h01234567;
    mode = 3'd0;
    @(negedge clk);
    check("R10", "outValid idle", {31'b0, outValid}, 32'd0);
    check("R10", "masks idle", {28'b0, wrMaskP, wrMaskQ}, 32'd0);
    check("R10", "resP held", resP, 32'h80000001);
    check("R10", "resQ held", resQ, 32'h7FFFFFFF);
    check("R10", "flags held", {24'b0, ovfFlag, carryFlag}, {24'b0, 4'b1000, 4'b1000});

    // R6: cross ignored in word mode
    opA = 32'h00010002;
    opB = 32'h00030004;
    mode = 3'd0;
    subLo = 1'b0;
    crossHalves = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    check("R6", "cross ignored word", resP, 32'h00040006);

    // R3: high-half wrap does not disturb low half
    mode = 3'd2;
    crossHalves = 1'b0;
    subHi = 1'b0;
    subLo = 1'b0;
    opA = 32'hFFFFFFFF;
    opB = 32'h00010000;
    @(negedge clk);
    check("R3", "pair wrap", resP, 32'h0000FFFF);
    check("R7", "pair wrap carry", {28'b0, carryFlag}, 32'h2);

    // R11: reset in mid-run clears outputs
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R11", "resP after reset", resP, 32'd0);
    check("R11", "flags after reset", {24'b0, ovfFlag, carryFlag}, 32'd0);
    check("R11", "outValid after reset", {31'b0, outValid}, 32'd0);

    done = 1'b1;
    finishRun();
  end

endmodule